// File: doc/BRIEF.md
# Programmable I2C SCL Clock Generator

This block produces the serial clock for an I2C master. Two count registers, each 16 bits wide, hold the length of the low phase and the length of the high phase in core clock cycles. The bit rate is therefore the core clock frequency divided by the sum of the two counts. Because the two counts are set separately, the duty cycle can be uneven. This meets the unequal low and high minimum times of fast-mode buses. The block does not check that the counts give a legal bus rate; choosing them is left to software.

The line is driven open-drain. `scl_pull_low` asserted means the pad pulls SCL to ground, and deasserted means the pad is released. The high phase is counted only while the sensed line reads high, so a slave that holds SCL low stretches the clock. Two single-cycle strobes mark the start of each low phase and the start of each counted high phase. A byte-level engine uses the first to place data changes and the second to sample data. When the block is disabled, the line is released.

Top module: `scl_clock_gen`

## Requirements
- R1: While enabled, every low phase keeps `scl_pull_low` asserted for exactly the low count latched for that period.
- R2: After the line is released, the next low phase begins once exactly the latched high count of cycles has passed with `scl_sense` high.
- R3: After reset, both count registers read back 4. `rd_data` returns the low count when `rd_sel` is 0 and the high count when `rd_sel` is 1.
- R4: A write with `wr_en` high stores `wr_data` into the low count when `wr_sel` is 0 and into the high count when `wr_sel` is 1. A value below 4 is stored as 4.
- R5: Both counts are copied for timing at the start of each low phase. A write made during a period does not change that period's phases.
- R6: With `en` high and the block idle, a low phase begins on the next clock. When `en` is low at a clock edge, `scl_pull_low` and both strobes are deasserted from then on.
- R7: During the high phase, cycles in which `scl_sense` reads low are not counted, so a slave that holds the line low lengthens the period.
- R8: `fall_stb` is high for exactly the first cycle of each low phase.
- R9: `rise_stb` is high for exactly the first cycle of the high phase in which `scl_sense` reads high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run the clock; low releases the line |
| wr_en | input | 1 | Count register write strobe |
| wr_sel | input | 1 | Write target: 0 low count, 1 high count |
| wr_data | input | 16 | Count value to write |
| rd_sel | input | 1 | Read source: 0 low count, 1 high count |
| rd_data | output | 16 | Selected count register |
| scl_sense | input | 1 | Sensed level of the SCL line |
| scl_pull_low | output | 1 | Open-drain drive: 1 pulls SCL low, 0 releases it |
| fall_stb | output | 1 | First cycle of a low phase |
| rise_stb | output | 1 | First counted high cycle |

## Verification
The bench targets writes that land in the middle of a period. A design that applied the new counts at once would shorten or lengthen the phase already running. It also writes values of 0 and 2. A generator that stored them unclamped would produce phases that are too short, or that never end because the count wraps. Slave stretches of several cycles are applied at the moment of release. A design that counted from the release instead of from the sensed high level would cut the high phase short and would fire the rise strobe too early. Disabling the block in mid-phase shows whether the line is released at once and whether the next enable starts again from a fresh low phase.

// File: rtl/scl_pkg.sv
package scl_pkg;

    localparam int CNT_W   = 16;
    localparam int MIN_CNT = 4;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } scl_phase_e;

    typedef struct packed {
        logic [CNT_W-1:0] lo;
        logic [CNT_W-1:0] hi;
    } scl_cfg_t;

    function automatic logic [CNT_W-1:0] floor_count(input logic [CNT_W-1:0] v);
        return (v < CNT_W'(MIN_CNT)) ? CNT_W'(MIN_CNT) : v;
    endfunction

endpackage

// File: rtl/scl_cnt_regs.sv
module scl_cnt_regs
    import scl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             rd_sel,
    output logic [CNT_W-1:0] rd_data,
    output scl_cfg_t         cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.lo <= CNT_W'(MIN_CNT);
            cfg.hi <= CNT_W'(MIN_CNT);
        end else if (wr_en) begin
            if (wr_sel) cfg.hi <= floor_count(wr_data);
            else        cfg.lo <= floor_count(wr_data);
        end
    end

    always_comb rd_data = rd_sel ? cfg.hi : cfg.lo;

    // R4
    lo_floor_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_sel && wr_data < CNT_W'(MIN_CNT)) |=> (cfg.lo == CNT_W'(MIN_CNT)));
    // R4
    hi_floor_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel && wr_data < CNT_W'(MIN_CNT)) |=> (cfg.hi == CNT_W'(MIN_CNT)));

endmodule

// File: rtl/scl_phase_ctrl.sv
module scl_phase_ctrl
    import scl_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  scl_cfg_t cfg_in,
    input  logic     scl_sense,
    output logic     scl_pull_low,
    output logic     fall_stb,
    output logic     rise_stb
);

    scl_phase_e       state;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_inc;
    scl_cfg_t         cfg_sh;
    logic             start_now;

    always_comb begin
        cnt_inc   = cnt + 1'b1;
        start_now = en && ((state == PH_IDLE) ||
                    (state == PH_HIGH && scl_sense && cnt_inc == cfg_sh.hi));
        rise_stb  = (state == PH_HIGH) && scl_sense && (cnt == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= PH_IDLE;
            cnt          <= '0;
            cfg_sh.lo    <= CNT_W'(MIN_CNT);
            cfg_sh.hi    <= CNT_W'(MIN_CNT);
            scl_pull_low <= 1'b0;
            fall_stb     <= 1'b0;
        end else begin
            fall_stb <= 1'b0;
            if (!en) begin
                state        <= PH_IDLE;
                cnt          <= '0;
                scl_pull_low <= 1'b0;
            end else if (start_now) begin
                state        <= PH_LOW;
                cnt          <= CNT_W'(1);
                cfg_sh       <= cfg_in;
                scl_pull_low <= 1'b1;
                fall_stb     <= 1'b1;
            end else if (state == PH_LOW) begin
                if (cnt == cfg_sh.lo) begin
                    state        <= PH_HIGH;
                    cnt          <= '0;
                    scl_pull_low <= 1'b0;
                end else begin
                    cnt <= cnt_inc;
                end
            end else if (state == PH_HIGH && scl_sense) begin
                cnt <= cnt_inc;
            end
        end
    end

    // R1
    low_len_chk: assert property (@(posedge clk) disable iff (rst)
        (state == PH_LOW) |-> (cnt <= cfg_sh.lo && scl_pull_low));
    // R5
    shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == PH_LOW && !fall_stb) |-> $stable(cfg_sh));
    // R6
    release_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!scl_pull_low && !fall_stb));
    // R7
    stretch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (en && state == PH_HIGH && !scl_sense) |=> $stable(cnt));
    // R8
    fall_drive_chk: assert property (@(posedge clk) disable iff (rst)
        fall_stb |-> scl_pull_low);
    // R9
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({fall_stb, rise_stb}));

endmodule

// File: rtl/scl_clock_gen.sv
module scl_clock_gen
    import scl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             rd_sel,
    output logic [CNT_W-1:0] rd_data,
    input  logic             scl_sense,
    output logic             scl_pull_low,
    output logic             fall_stb,
    output logic             rise_stb
);

    scl_cfg_t cfg;

    scl_cnt_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .rd_sel  (rd_sel),
        .rd_data (rd_data),
        .cfg     (cfg)
    );

    scl_phase_ctrl u_phase (
        .clk          (clk),
        .rst          (rst),
        .en           (en),
        .cfg_in       (cfg),
        .scl_sense    (scl_sense),
        .scl_pull_low (scl_pull_low),
        .fall_stb     (fall_stb),
        .rise_stb     (rise_stb)
    );

endmodule

// File: tb/scl_clock_gen_test.sv
module scl_clock_gen_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [15:0] wr_data = '0;
    logic        rd_sel = 1'b0;
    logic [15:0] rd_data;
    logic        scl_sense;
    logic        scl_pull_low;
    logic        fall_stb;
    logic        rise_stb;
    logic        stretch = 1'b0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    assign scl_sense = !scl_pull_low && !stretch;

    scl_clock_gen uut (
        .clk(clk), .rst(rst), .en(en), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .scl_sense(scl_sense), .scl_pull_low(scl_pull_low),
        .fall_stb(fall_stb), .rise_stb(rise_stb)
    );

    // behavioural reference: registers, run flag, current phase and its age
    int  m_lo = 4, m_hi = 4;
    int  m_run_lo = 4, m_run_hi = 4;
    bit  m_active = 0, m_low = 0, m_pull = 0, m_fall = 0;
    int  m_age = 0;

    always @(posedge clk) begin
        int nlo, nhi;
        bit begin_period;
        cycles++;
        nlo = m_lo; nhi = m_hi;
        if (wr_en) begin
            if (wr_sel) nhi = (wr_data < 4) ? 4 : int'(wr_data);
            else        nlo = (wr_data < 4) ? 4 : int'(wr_data);
        end
        if (rst) begin
            m_lo = 4; m_hi = 4; m_run_lo = 4; m_run_hi = 4;
            m_active = 0; m_low = 0; m_pull = 0; m_fall = 0; m_age = 0;
        end else begin
            begin_period = 0;
            m_fall = 0;
            if (!en) begin
                m_active = 0; m_pull = 0; m_age = 0;
            end else if (!m_active) begin
                begin_period = 1;
            end else if (m_low) begin
                if (m_age >= m_run_lo) begin
                    m_low = 0; m_pull = 0; m_age = 0;
                end else m_age++;
            end else if (scl_sense) begin
                if (m_age + 1 >= m_run_hi) begin_period = 1;
                else m_age++;
            end
            if (begin_period) begin
                m_run_lo = m_lo; m_run_hi = m_hi;
                m_active = 1; m_low = 1; m_age = 1; m_pull = 1; m_fall = 1;
            end
            m_lo = nlo; m_hi = nhi;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cycles);
        end
    endtask

    // compare against the reference on every falling edge
    always @(negedge clk) begin
        bit exp_rise;
        int exp_rd;
        if (!rst) begin
            exp_rise = m_active && !m_low && m_age == 0 && scl_sense;
            exp_rd   = rd_sel ? m_hi : m_lo;
            check(scl_pull_low == m_pull, m_low ? "R1 R5 R6 pull" : "R2 R5 R6 R7 pull",
                  scl_pull_low, m_pull);
            check(fall_stb == m_fall, "R8 fall_stb", fall_stb, m_fall);
            check(rise_stb == exp_rise, "R9 rise_stb", rise_stb, exp_rise);
            check(int'(rd_data) == exp_rd, "R3 R4 rd_data", rd_data, exp_rd);
        end
    end

    task automatic write_cnt(input bit sel, input logic [15:0] val);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = val;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R3 reset values
        @(negedge clk);
        rd_sel = 1'b0; #0.1;
        check(rd_data == 16'd4, "R3 reset low count", rd_data, 4);
        rd_sel = 1'b1; #0.1;
        check(rd_data == 16'd4, "R3 reset high count", rd_data, 4);
        check(scl_pull_low == 1'b0, "R6 idle released", scl_pull_low, 0);

        // R6 enable with default counts
        en = 1'b1;
        idle(30);

        // R5 asymmetric counts written mid-period
        write_cnt(1'b0, 16'd10);
        write_cnt(1'b1, 16'd6);
        idle(70);

        // R4 values below the floor
        write_cnt(1'b0, 16'd2);
        write_cnt(1'b1, 16'd0);
        rd_sel = 1'b0; #0.1;
        check(rd_data == 16'd4, "R4 low clamped", rd_data, 4);
        rd_sel = 1'b1; #0.1;
        check(rd_data == 16'd4, "R4 high clamped", rd_data, 4);
        idle(40);

        // R7 slave stretching
        write_cnt(1'b0, 16'd8);
        write_cnt(1'b1, 16'd5);
        for (int k = 0; k < 4; k++) begin
            while (!scl_pull_low) @(negedge clk);
            while (scl_pull_low) @(negedge clk);
            stretch = 1'b1;
            idle(3 + 2 * k);
            stretch = 1'b0;
        end
        idle(30);

        // R6 disable in mid-phase, then restart
        while (!scl_pull_low) @(negedge clk);
        idle(3);
        en = 1'b0;
        idle(2);
        check(scl_pull_low == 1'b0, "R6 released on disable", scl_pull_low, 0);
        idle(5);
        en = 1'b1;
        idle(40);

        // R4 a large value and readback
        write_cnt(1'b1, 16'h0123);
        rd_sel = 1'b1; #0.1;
        check(rd_data == 16'h0123, "R4 wide value stored", rd_data, 16'h0123);
        idle(20);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule